// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block moves a processor subsystem between its run modes (normal, very-low-power and high-speed) and its wait and stop modes. The CPU picks a target with a request code and fires a one-cycle sleep trigger. A wait entry gates only the CPU clock. A stop entry steps through a fixed sequence: it gates the CPU clock, then the system clocks, then raises a request to the power-management regulator and waits for its acknowledge. When the regulator confirms, the block reports the stop mode. Leaving stop runs the same steps backwards.

While the regulator handoff has not yet begun, an interrupt or a reset event cancels a stop entry. The block then returns straight to normal run and sets a sticky aborted flag. Once the regulator request is raised, interrupts and reset events are held off. They act as wake-ups only after the regulator has acknowledged stop regulation. When debug is enabled, a debug request in any wait or stop mode moves the block to a halted state with full run clocking.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the asynchronous reset the block reports mode code 0 (normal run), with both clock enables at 1, the regulator request at 0 and the aborted flag at 0.
- R2: A sleep trigger with request code 2, 3 or 4 switches the run mode to normal run (code 0), very-low-power run (code 1) or high-speed run (code 2) on the next cycle. High-speed run is legal only from normal or high-speed run. Very-low-power run is legal only from normal or very-low-power run.
- R3: A sleep trigger with request code 0 from normal run enters wait (mode 3), and from very-low-power run enters very-low-power wait (mode 4). On the next cycle the CPU clock enable drops and the system clock enable stays at 1. An interrupt sampled in wait returns to the originating run mode on the next cycle, with the CPU clock re-enabled.
- R4: A sleep trigger with request code 1 starts stop entry. The first cycle gates the CPU clock, the second also gates the system clocks, and the third raises the regulator request. The mode becomes stop (5) from normal run, or very-low-power stop (6) from very-low-power run, one cycle after the acknowledge is sampled.
- R5: An interrupt or reset event sampled during either of the first two stop-entry cycles returns the block to normal run on the next cycle. Both clocks come back on, the regulator request is never raised, and the aborted flag becomes 1.
- R6: While the regulator request is up and the acknowledge has not arrived, interrupts and reset events change no output. A held-off interrupt triggers the exit sequence on the cycle after stop is reported.
- R7: Stop exit drops the regulator request on the cycle after the wake-up. It then re-enables the system clocks one cycle after the acknowledge is sampled low. On the cycle after that it re-enables the CPU clock and reports the destination mode.
- R8: The aborted flag stays at 1 until the asynchronous reset or until the cycle in which a later stop entry raises the regulator request.
- R9: With debug enabled, a debug request in wait or stop leads to halted (mode 7) with both clocks on. From stop this goes through the exit sequence. With debug disabled the request has no effect. Dropping the debug request leaves halted for the run mode that was active before the low-power entry.
- R10: A sleep trigger with an illegal request has no effect. Illegal requests are: wait or stop from high-speed run, codes 5 to 7, high-speed run from very-low-power run, and very-low-power run from high-speed run.
- R11: A reset event in any run mode, in wait, in halted or in stop returns the block to normal run. From stop this goes through the exit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep / mode-change trigger from the CPU |
| req_mode_i | input | 3 | Requested mode code (0 wait, 1 stop, 2 run, 3 very-low-power run, 4 high-speed run) |
| irq_i | input | 1 | Interrupt wake-up |
| rst_req_i | input | 1 | Synchronous reset event |
| dbg_en_i | input | 1 | Debugger enabled |
| dbg_req_i | input | 1 | Debug halt request |
| reg_ack_i | input | 1 | Regulator acknowledge of stop regulation |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| sys_clk_en_o | output | 1 | System clock gate enable |
| reg_req_o | output | 1 | Stop-regulation request to the regulator |
| mode_o | output | 3 | Current mode code |
| stop_abort_o | output | 1 | Sticky stop-entry aborted flag |

## Verification
Stop entry is exercised with an interrupt in the first gating cycle, with a reset event in the second, and with an interrupt after the request is raised. Together these separate the abort window from the hold-off window. Regulator acknowledge latencies of different lengths show whether the block waits on the handshake or on a fixed count. Wait and stop entries are made from both normal and very-low-power run, so a wrong choice of low-power variant or a wrong return target shows up. Legal and illegal request codes are applied from every run mode to confirm that the legality matrix is enforced.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int MODE_W = 3;
  localparam int REQ_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    M_RUN = 3'd0, M_VLPR = 3'd1, M_HSRUN = 3'd2, M_WAIT = 3'd3,
    M_VLPW = 3'd4, M_STOP = 3'd5, M_VLPS = 3'd6, M_HALT = 3'd7
  } pwr_mode_e;

  localparam logic [REQ_W-1:0] REQ_WAIT  = 3'd0;
  localparam logic [REQ_W-1:0] REQ_STOP  = 3'd1;
  localparam logic [REQ_W-1:0] REQ_RUN   = 3'd2;
  localparam logic [REQ_W-1:0] REQ_VLPR  = 3'd3;
  localparam logic [REQ_W-1:0] REQ_HSRUN = 3'd4;

  typedef enum logic [3:0] {
    ST_RUN, ST_WAIT, ST_ENT_CPU, ST_ENT_SYS, ST_ENT_REG,
    ST_STOP, ST_EXT_REG, ST_EXT_SYS, ST_HALT
  } seq_state_e;
endpackage

// File: rtl/pms_req_decode.sv
module pms_req_decode
  import pms_pkg::*;
(
  input  pwr_mode_e        base_i,
  input  logic [REQ_W-1:0] req_i,
  output logic             want_wait_o,
  output logic             want_stop_o,
  output logic             want_run_o,
  output pwr_mode_e        new_run_o
);
  always_comb begin
    want_wait_o = 1'b0;
    want_stop_o = 1'b0;
    want_run_o  = 1'b0;
    new_run_o   = base_i;
    case (req_i)
      REQ_WAIT:  want_wait_o = (base_i != M_HSRUN);
      REQ_STOP:  want_stop_o = (base_i != M_HSRUN);
      REQ_RUN: begin
        want_run_o = 1'b1;
        new_run_o  = M_RUN;
      end
      REQ_VLPR: if (base_i != M_HSRUN) begin
        want_run_o = 1'b1;
        new_run_o  = M_VLPR;
      end
      REQ_HSRUN: if (base_i != M_VLPR) begin
        want_run_o = 1'b1;
        new_run_o  = M_HSRUN;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pms_abort_flag.sv
module pms_abort_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pms_seq_fsm.sv
module pms_seq_fsm
  import pms_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sleep_i,
  input  logic      want_wait_i,
  input  logic      want_stop_i,
  input  logic      want_run_i,
  input  pwr_mode_e new_run_i,
  input  logic      irq_i,
  input  logic      rst_req_i,
  input  logic      dbg_en_i,
  input  logic      dbg_req_i,
  input  logic      reg_ack_i,
  output pwr_mode_e base_o,
  output pwr_mode_e mode_o,
  output logic      cpu_clk_en_o,
  output logic      sys_clk_en_o,
  output logic      reg_req_o,
  output logic      abort_o,
  output logic      commit_o
);
  seq_state_e state_q, state_d;
  pwr_mode_e  mode_q, mode_d, base_q, base_d, dest_q, dest_d;
  logic       pend_irq_q, pend_irq_d, pend_rst_q, pend_rst_d;
  logic       dbg_hit;

  assign dbg_hit = dbg_en_i & dbg_req_i;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    base_d     = base_q;
    dest_d     = dest_q;
    pend_irq_d = pend_irq_q;
    pend_rst_d = pend_rst_q;
    abort_o    = 1'b0;
    commit_o   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (rst_req_i) begin
          base_d = M_RUN;
          mode_d = M_RUN;
        end else if (sleep_i) begin
          if (want_run_i) begin
            base_d = new_run_i;
            mode_d = new_run_i;
          end else if (want_wait_i) begin
            state_d = ST_WAIT;
            mode_d  = (base_q == M_VLPR) ? M_VLPW : M_WAIT;
          end else if (want_stop_i) begin
            state_d = ST_ENT_CPU;
          end
        end
      end
      ST_WAIT: begin
        if (rst_req_i) begin
          state_d = ST_RUN;
          base_d  = M_RUN;
          mode_d  = M_RUN;
        end else if (dbg_hit) begin
          state_d = ST_HALT;
          mode_d  = M_HALT;
        end else if (irq_i) begin
          state_d = ST_RUN;
          mode_d  = base_q;
        end
      end
      ST_ENT_CPU, ST_ENT_SYS: begin
        if (irq_i || rst_req_i) begin
          state_d = ST_RUN;
          base_d  = M_RUN;
          mode_d  = M_RUN;
          abort_o = 1'b1;
        end else if (state_q == ST_ENT_CPU) begin
          state_d = ST_ENT_SYS;
        end else begin
          state_d  = ST_ENT_REG;
          commit_o = 1'b1;
        end
      end
      ST_ENT_REG: begin
        // wake events held off until the regulator confirms
        pend_irq_d = pend_irq_q | irq_i;
        pend_rst_d = pend_rst_q | rst_req_i;
        if (reg_ack_i) begin
          state_d = ST_STOP;
          mode_d  = (base_q == M_VLPR) ? M_VLPS : M_STOP;
        end
      end
      ST_STOP: begin
        if (rst_req_i || pend_rst_q) begin
          dest_d  = M_RUN;
          base_d  = M_RUN;
          state_d = ST_EXT_REG;
        end else if (dbg_hit) begin
          dest_d  = M_HALT;
          state_d = ST_EXT_REG;
        end else if (irq_i || pend_irq_q) begin
          dest_d  = base_q;
          state_d = ST_EXT_REG;
        end
        if (state_d == ST_EXT_REG) begin
          pend_irq_d = 1'b0;
          pend_rst_d = 1'b0;
        end
      end
      ST_EXT_REG: if (!reg_ack_i) state_d = ST_EXT_SYS;
      ST_EXT_SYS: begin
        state_d = (dest_q == M_HALT) ? ST_HALT : ST_RUN;
        mode_d  = dest_q;
      end
      ST_HALT: begin
        if (rst_req_i) begin
          state_d = ST_RUN;
          base_d  = M_RUN;
          mode_d  = M_RUN;
        end else if (!dbg_req_i) begin
          state_d = ST_RUN;
          mode_d  = base_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      mode_q     <= M_RUN;
      base_q     <= M_RUN;
      dest_q     <= M_RUN;
      pend_irq_q <= 1'b0;
      pend_rst_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      base_q     <= base_d;
      dest_q     <= dest_d;
      pend_irq_q <= pend_irq_d;
      pend_rst_q <= pend_rst_d;
    end
  end

  assign base_o       = base_q;
  assign mode_o       = mode_q;
  assign cpu_clk_en_o = (state_q == ST_RUN) || (state_q == ST_HALT);
  assign sys_clk_en_o = (state_q == ST_RUN) || (state_q == ST_HALT) || (state_q == ST_WAIT) ||
                        (state_q == ST_ENT_CPU) || (state_q == ST_EXT_SYS);
  assign reg_req_o    = (state_q == ST_ENT_REG) || (state_q == ST_STOP);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [REQ_W-1:0]  req_mode_i,
  input  logic              irq_i,
  input  logic              rst_req_i,
  input  logic              dbg_en_i,
  input  logic              dbg_req_i,
  input  logic              reg_ack_i,
  output logic              cpu_clk_en_o,
  output logic              sys_clk_en_o,
  output logic              reg_req_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              stop_abort_o
);
  pwr_mode_e base, new_run, mode;
  logic      want_wait, want_stop, want_run, abort_set, commit;

  pms_req_decode u_dec (
    .base_i      (base),
    .req_i       (req_mode_i),
    .want_wait_o (want_wait),
    .want_stop_o (want_stop),
    .want_run_o  (want_run),
    .new_run_o   (new_run)
  );

  pms_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_i      (sleep_i),
    .want_wait_i  (want_wait),
    .want_stop_i  (want_stop),
    .want_run_i   (want_run),
    .new_run_i    (new_run),
    .irq_i        (irq_i),
    .rst_req_i    (rst_req_i),
    .dbg_en_i     (dbg_en_i),
    .dbg_req_i    (dbg_req_i),
    .reg_ack_i    (reg_ack_i),
    .base_o       (base),
    .mode_o       (mode),
    .cpu_clk_en_o (cpu_clk_en_o),
    .sys_clk_en_o (sys_clk_en_o),
    .reg_req_o    (reg_req_o),
    .abort_o      (abort_set),
    .commit_o     (commit)
  );

  pms_abort_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (abort_set),
    .clr_i  (commit),
    .flag_o (stop_abort_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_ack_i,
  input logic       cpu_clk_en_o,
  input logic       sys_clk_en_o,
  input logic       reg_req_o,
  input logic [2:0] mode_o,
  input logic       stop_abort_o
);
  AST_REQ_CLOCKS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (!cpu_clk_en_o && !sys_clk_en_o)); // R4
  AST_SYS_AFTER_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_clk_en_o |-> !cpu_clk_en_o); // R7
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_ack_i) |=> reg_req_o); // R6
  AST_ABORT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_abort_o) |-> (!reg_req_o && cpu_clk_en_o && sys_clk_en_o)); // R5
  AST_ABORT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_abort_o) |-> reg_req_o); // R8
  AST_WAIT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 || mode_o == 3'd4) |-> (sys_clk_en_o && !cpu_clk_en_o)); // R3
  AST_HALT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7) |-> (sys_clk_en_o && cpu_clk_en_o)); // R9
endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_ack_i    (reg_ack_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .sys_clk_en_o (sys_clk_en_o),
  .reg_req_o    (reg_req_o),
  .mode_o       (mode_o),
  .stop_abort_o (stop_abort_o)
);

// File: tb/test_pwr_mode_seq.sv
`timescale 1ns/1ps
module test_pwr_mode_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0;
  logic [2:0] req_mode_i = 3'd0;
  logic       irq_i = 1'b0, rst_req_i = 1'b0, dbg_en_i = 1'b0, dbg_req_i = 1'b0;
  logic       reg_ack_i = 1'b0;
  logic       cpu_clk_en_o, sys_clk_en_o, reg_req_o, stop_abort_o;
  logic [2:0] mode_o;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  int ack_lat = 3, ack_cnt = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pwr_mode_seq i_pwr_mode_seq (.*);

  // behavioural reference: phase 0 settled, 1/2 gating, 3 handshake, 4 stop, 5/6 exit
  int ph, em, eb, ed;
  bit ea, pi, pr;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph = 0; em = 0; eb = 0; ed = 0; ea = 0; pi = 0; pr = 0;
    end else begin
      case (ph)
        0: begin
          if (em <= 2) begin
            if (rst_req_i) em = 0;
            else if (sleep_i) begin
              case (req_mode_i)
                3'd0: if (em != 2) begin eb = em; em = (em == 1) ? 4 : 3; end
                3'd1: if (em != 2) begin eb = em; ph = 1; end
                3'd2: em = 0;
                3'd3: if (em != 2) em = 1;
                3'd4: if (em != 1) em = 2;
                default: ;
              endcase
            end
          end else if (em == 3 || em == 4) begin
            if (rst_req_i) em = 0;
            else if (dbg_en_i && dbg_req_i) em = 7;
            else if (irq_i) em = eb;
          end else begin
            if (rst_req_i) em = 0;
            else if (!dbg_req_i) em = eb;
          end
        end
        1, 2: begin
          if (irq_i || rst_req_i) begin ph = 0; em = 0; ea = 1; end
          else begin ph = ph + 1; if (ph == 3) ea = 0; end
        end
        3: begin
          pi = pi | irq_i; pr = pr | rst_req_i;
          if (reg_ack_i) begin ph = 4; em = (eb == 1) ? 6 : 5; end
        end
        4: begin
          if (rst_req_i || pr) begin ed = 0; ph = 5; end
          else if (dbg_en_i && dbg_req_i) begin ed = 7; ph = 5; end
          else if (irq_i || pi) begin ed = eb; ph = 5; end
          if (ph == 5) begin pi = 0; pr = 0; end
        end
        5: if (!reg_ack_i) ph = 6;
        default: begin ph = 0; em = ed; end
      endcase
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  // per-cycle comparison and regulator model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R1 mode", int'(mode_o), em);
      check("R3 cpu clock", int'(cpu_clk_en_o), int'(ph == 0 && (em <= 2 || em == 7)));
      check("R4 sys clock", int'(sys_clk_en_o),
            int'((ph == 0 && (em <= 4 || em == 7)) || ph == 1 || ph == 6));
      check("R4 regulator request", int'(reg_req_o), int'(ph == 3 || ph == 4));
      check("R8 abort flag", int'(stop_abort_o), int'(ea));
    end
    if (reg_req_o != reg_ack_i) begin
      ack_cnt++;
      if (ack_cnt >= ack_lat) begin reg_ack_i <= reg_req_o; ack_cnt = 0; end
    end else ack_cnt = 0;
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cyc_cnt++;
      if (cyc_cnt > 20000 && !done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic trig(logic [2:0] code);
    req_mode_i = code; sleep_i = 1'b1; cyc(); sleep_i = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_i = 1'b1; cyc(); irq_i = 1'b0;
  endtask

  task automatic wait_mode(int m);
    for (int i = 0; i < 50 && int'(mode_o) != m; i++) cyc();
  endtask

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset mode", int'(mode_o), 0);
    check("R1 reset clocks", int'({cpu_clk_en_o, sys_clk_en_o, reg_req_o, stop_abort_o}), 4'b1100);

    // wait from normal run
    trig(3'd0);
    check("R3 wait mode", int'(mode_o), 3);
    check("R3 wait clocks", int'({cpu_clk_en_o, sys_clk_en_o}), 2'b01);
    dbg_req_i = 1'b1; cyc(2); dbg_req_i = 1'b0;
    check("R9 debug ignored when disabled", int'(mode_o), 3);
    pulse_irq();
    check("R3 wake to run", int'(mode_o), 0);
    check("R3 cpu clock back", int'(cpu_clk_en_o), 1);

    // run mode changes and illegal requests
    trig(3'd3); check("R2 to VLPR", int'(mode_o), 1);
    trig(3'd4); check("R10 HSRUN from VLPR ignored", int'(mode_o), 1);
    trig(3'd0); check("R3 VLPW", int'(mode_o), 4);
    pulse_irq(); check("R3 back to VLPR", int'(mode_o), 1);
    trig(3'd2); check("R2 to RUN", int'(mode_o), 0);
    trig(3'd4); check("R2 to HSRUN", int'(mode_o), 2);
    trig(3'd1); cyc(3);
    check("R10 stop from HSRUN ignored", int'({mode_o, cpu_clk_en_o, reg_req_o}), {3'd2, 1'b1, 1'b0});
    trig(3'd0); check("R10 wait from HSRUN ignored", int'(mode_o), 2);
    trig(3'd3); check("R10 VLPR from HSRUN ignored", int'(mode_o), 2);
    trig(3'd6); check("R10 undefined code ignored", int'(mode_o), 2);
    rst_req_i = 1'b1; cyc(); rst_req_i = 1'b0;
    check("R11 reset event to RUN", int'(mode_o), 0);

    // full stop entry and exit
    trig(3'd1);
    check("R4 step1 clocks", int'({cpu_clk_en_o, sys_clk_en_o, reg_req_o}), 3'b010);
    cyc(); check("R4 step2 clocks", int'({cpu_clk_en_o, sys_clk_en_o, reg_req_o}), 3'b000);
    cyc(); check("R4 step3 request", int'(reg_req_o), 1);
    wait_mode(5); check("R4 stop reported", int'(mode_o), 5);
    pulse_irq();
    check("R7 request dropped", int'({reg_req_o, mode_o}), {1'b0, 3'd5});
    for (int i = 0; i < 20 && !sys_clk_en_o; i++) cyc();
    check("R7 sys before cpu", int'({cpu_clk_en_o, sys_clk_en_o}), 2'b01);
    cyc(); check("R7 cpu and mode restored", int'({cpu_clk_en_o, mode_o}), {1'b1, 3'd0});

    // abort in first step by interrupt
    trig(3'd1); pulse_irq();
    check("R5 abort returns to RUN", int'({mode_o, cpu_clk_en_o, sys_clk_en_o, reg_req_o}), {3'd0, 3'b110});
    check("R5 abort flag set", int'(stop_abort_o), 1);
    // abort in second step by reset event
    trig(3'd3); trig(3'd1); cyc();
    rst_req_i = 1'b1; cyc(); rst_req_i = 1'b0;
    check("R5 reset-event abort to RUN", int'(mode_o), 0);
    cyc(5); check("R8 flag sticky", int'(stop_abort_o), 1);

    // successful entry clears flag; interrupt held off
    ack_lat = 6;
    trig(3'd1); cyc(2);
    check("R8 flag cleared on request", int'({reg_req_o, stop_abort_o}), 2'b10);
    pulse_irq(); cyc();
    check("R6 interrupt held off", int'({reg_req_o, mode_o, cpu_clk_en_o}), {1'b1, 3'd0, 1'b0});
    wait_mode(5); check("R6 stop reached after hold-off", int'(mode_o), 5);
    cyc(); check("R6 held wake starts exit", int'(reg_req_o), 0);
    wait_mode(0); check("R6 back in RUN", int'(mode_o), 0);

    // VLPS then debug halt
    ack_lat = 2;
    trig(3'd3); trig(3'd1);
    wait_mode(6); check("R4 VLPS reported", int'(mode_o), 6);
    dbg_en_i = 1'b1; dbg_req_i = 1'b1;
    wait_mode(7); check("R9 halted from stop", int'({mode_o, cpu_clk_en_o, sys_clk_en_o}), {3'd7, 2'b11});
    dbg_req_i = 1'b0; cyc();
    check("R9 halt exit to VLPR", int'(mode_o), 1);

    // wait -> halt -> reset event
    trig(3'd0); dbg_req_i = 1'b1; cyc();
    check("R9 halted from wait", int'(mode_o), 7);
    rst_req_i = 1'b1; cyc(); rst_req_i = 1'b0; dbg_req_i = 1'b0;
    check("R11 reset event leaves halt", int'(mode_o), 0);

    // reset event wakes stop
    trig(3'd3); trig(3'd1); wait_mode(6);
    rst_req_i = 1'b1; cyc(); rst_req_i = 1'b0;
    wait_mode(0); check("R11 stop exit to RUN", int'({mode_o, cpu_clk_en_o}), {3'd0, 1'b1});

    // hardware reset clears sticky flag
    trig(3'd1); pulse_irq();
    check("R5 abort again", int'(stop_abort_o), 1);
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1; @(negedge clk_i);
    check("R8 reset clears flag", int'({stop_abort_o, mode_o}), {1'b0, 3'd0});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule